// File: doc/BRIEF.md
# Voltage-Frequency Transition Sequencer

This block moves a core's operating point from its present clock ratio and supply voltage code to a new target. A target arrives as a ratio and a voltage code with a one-cycle valid strobe. The sequence then starts by itself and needs no further input. The block drives a voltage-regulator handshake (a request with an acknowledge) and a clock-ratio handshake (a request with a lock acknowledge). It orders the two steps by the direction of the ratio change: a rising ratio raises the voltage first, and a falling ratio changes the clock first. A step whose component already matches the target is skipped.

While the clock ratio is changing, the block raises a stall output that holds instruction execution. During a voltage step, execution continues. A target that arrives while a sequence is running is held in a single pending slot, where a later target overwrites an earlier one. The held target runs once the active sequence ends. The current point and a busy flag are always visible at the ports.

Top module: `vfseq_top`

## Requirements
- R1: Out of reset, curRatio and curVcode equal the RESET_RATIO and RESET_VCODE parameters (defaults 16 and 40), and busy, vrReq, clkReq and stall are all 0.
- R2: A tgtValid pulse starts a sequence with no further input. busy is 1 from the first edge after the pulse. The first request, if any, is driven from the second edge after the pulse.
- R3: When the target ratio is greater than curRatio, the voltage step (vrReq) completes before the clock step (clkReq) begins.
- R4: When the target ratio is less than or equal to curRatio, the clock step completes before the voltage step begins.
- R5: A step is skipped when its component of the target already equals the current value. Each differing component gets exactly one request.
- R6: stall is 1 exactly in cycles where clkReq is 1 and clkLockAck is 0. It is never 1 during a voltage step.
- R7: vrReq and clkReq are never 1 together. Each request holds its code (vrCode or clkRatio) stable until its acknowledge. The matching current value takes the code on the edge that samples the acknowledge.
- R8: A target equal to the current point issues no request. It keeps busy at 1 for exactly two cycles.
- R9: A target arriving while busy is held, and a later one overwrites it. The held target is run after the active sequence finishes, so an overwritten target is never applied.
- R10: busy is 0 only when no sequence runs and no target is pending. Both requests are 0 whenever busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tgtValid | input | 1 | Target strobe |
| tgtRatio | input | RATIO_W | Target clock ratio |
| tgtVcode | input | VCODE_W | Target voltage code |
| vrReq | output | 1 | Voltage change request |
| vrCode | output | VCODE_W | Voltage code being requested |
| vrAck | input | 1 | Regulator acknowledge |
| clkReq | output | 1 | Clock ratio change request |
| clkRatio | output | RATIO_W | Ratio being requested |
| clkLockAck | input | 1 | Clock lock acknowledge |
| stall | output | 1 | Hold instruction execution |
| curRatio | output | RATIO_W | Present clock ratio |
| curVcode | output | VCODE_W | Present voltage code |
| busy | output | 1 | Sequence active or target pending |

## Verification
Timing is counted from the tgtValid pulse:
- busy rises one edge after the pulse.
- A request appears two edges after the pulse.
- The current value changes on the edge that samples its acknowledge.
- The request drops on that same edge.
- An equal target leaves busy high for two cycles.

stall depends combinationally on the lock acknowledge. The bench therefore drives both acknowledges on the falling edge and samples every output a step later in the same low phase, so each check sees settled values. Every vector waits for busy to fall before it compares the final point, the request counts and the request order.

// File: rtl/vfseq_pkg.sv
package vfseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_VOLT = 2'd1,
    ST_FREQ = 2'd2,
    ST_DONE = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadWork;
    logic commitVolt;
    logic commitFreq;
  } seqCtl_t;

  // comparison results from datapath to control
  typedef struct packed {
    logic pendValid;
    logic pendUp;
    logic pendRatioDiff;
    logic pendVcodeDiff;
    logic workUp;
    logic workRatioDiff;
    logic workVcodeDiff;
  } seqFlags_t;

endpackage

// File: rtl/vfseq_datapath.sv
module vfseq_datapath
  import vfseq_pkg::*;
#(
  parameter int RATIO_W     = 8,
  parameter int VCODE_W     = 8,
  parameter int RESET_RATIO = 16,
  parameter int RESET_VCODE = 40
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tgtValid,
  input  logic [RATIO_W-1:0] tgtRatio,
  input  logic [VCODE_W-1:0] tgtVcode,
  input  seqCtl_t            ctl,
  output seqFlags_t          flags,
  output logic [RATIO_W-1:0] curRatio,
  output logic [VCODE_W-1:0] curVcode,
  output logic [RATIO_W-1:0] workRatio,
  output logic [VCODE_W-1:0] workVcode
);

  localparam logic [RATIO_W-1:0] RatioInit = RATIO_W'(RESET_RATIO);
  localparam logic [VCODE_W-1:0] VcodeInit = VCODE_W'(RESET_VCODE);

  logic               pendValid;
  logic [RATIO_W-1:0] pendRatio;
  logic [VCODE_W-1:0] pendVcode;
  logic               upDir;

  // pending slot: newest strobe wins, consumption only clears when no new strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendRatio <= '0;
      pendVcode <= '0;
    end else if (tgtValid) begin
      pendValid <= 1'b1;
      pendRatio <= tgtRatio;
      pendVcode <= tgtVcode;
    end else if (ctl.loadWork) begin
      pendValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      workRatio <= RatioInit;
      workVcode <= VcodeInit;
      upDir     <= 1'b0;
    end else if (ctl.loadWork) begin
      workRatio <= pendRatio;
      workVcode <= pendVcode;
      upDir     <= pendRatio > curRatio;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curRatio <= RatioInit;
      curVcode <= VcodeInit;
    end else begin
      if (ctl.commitFreq) curRatio <= workRatio;
      if (ctl.commitVolt) curVcode <= workVcode;
    end
  end

  always_comb begin
    flags.pendValid     = pendValid;
    flags.pendUp        = pendRatio > curRatio;
    flags.pendRatioDiff = pendRatio != curRatio;
    flags.pendVcodeDiff = pendVcode != curVcode;
    flags.workUp        = upDir;
    flags.workRatioDiff = workRatio != curRatio;
    flags.workVcodeDiff = workVcode != curVcode;
  end

endmodule

// File: rtl/vfseq_control.sv
module vfseq_control
  import vfseq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  seqFlags_t flags,
  input  logic      vrAck,
  input  logic      clkLockAck,
  output seqCtl_t   ctl,
  output logic      vrReq,
  output logic      clkReq,
  output logic      stall,
  output logic      busy
);

  seqState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (flags.pendValid) begin
          if (flags.pendUp)
            stateNext = ST_VOLT;
          else if (flags.pendRatioDiff)
            stateNext = ST_FREQ;
          else if (flags.pendVcodeDiff)
            stateNext = ST_VOLT;
          else
            stateNext = ST_DONE;
          // rising ratio with unchanged voltage goes straight to the clock
          if (flags.pendUp && !flags.pendVcodeDiff)
            stateNext = ST_FREQ;
        end
      end
      ST_VOLT: begin
        if (vrAck)
          stateNext = (flags.workUp && flags.workRatioDiff) ? ST_FREQ : ST_DONE;
      end
      ST_FREQ: begin
        if (clkLockAck)
          stateNext = (!flags.workUp && flags.workVcodeDiff) ? ST_VOLT : ST_DONE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl.loadWork   = (state == ST_IDLE) && flags.pendValid;
    ctl.commitVolt = (state == ST_VOLT) && vrAck;
    ctl.commitFreq = (state == ST_FREQ) && clkLockAck;
  end

  assign vrReq  = state == ST_VOLT;
  assign clkReq = state == ST_FREQ;
  assign stall  = (state == ST_FREQ) && !clkLockAck;
  assign busy   = (state != ST_IDLE) || flags.pendValid;

endmodule

// File: rtl/vfseq_top.sv
module vfseq_top
  import vfseq_pkg::*;
#(
  parameter int RATIO_W     = 8,
  parameter int VCODE_W     = 8,
  parameter int RESET_RATIO = 16,
  parameter int RESET_VCODE = 40
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tgtValid,
  input  logic [RATIO_W-1:0] tgtRatio,
  input  logic [VCODE_W-1:0] tgtVcode,
  output logic               vrReq,
  output logic [VCODE_W-1:0] vrCode,
  input  logic               vrAck,
  output logic               clkReq,
  output logic [RATIO_W-1:0] clkRatio,
  input  logic               clkLockAck,
  output logic               stall,
  output logic [RATIO_W-1:0] curRatio,
  output logic [VCODE_W-1:0] curVcode,
  output logic               busy
);

  seqCtl_t   ctl;
  seqFlags_t flags;

  vfseq_datapath #(
    .RATIO_W(RATIO_W), .VCODE_W(VCODE_W),
    .RESET_RATIO(RESET_RATIO), .RESET_VCODE(RESET_VCODE)
  ) uDatapath (
    .clk(clk), .rstN(rstN), .tgtValid(tgtValid), .tgtRatio(tgtRatio),
    .tgtVcode(tgtVcode), .ctl(ctl), .flags(flags), .curRatio(curRatio),
    .curVcode(curVcode), .workRatio(clkRatio), .workVcode(vrCode)
  );

  vfseq_control uControl (
    .clk(clk), .rstN(rstN), .flags(flags), .vrAck(vrAck),
    .clkLockAck(clkLockAck), .ctl(ctl), .vrReq(vrReq), .clkReq(clkReq),
    .stall(stall), .busy(busy)
  );

endmodule

// File: rtl/vfseq_checker.sv
module vfseq_checker #(
  parameter int RATIO_W = 8,
  parameter int VCODE_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               vrReq,
  input logic [VCODE_W-1:0] vrCode,
  input logic               vrAck,
  input logic               clkReq,
  input logic [RATIO_W-1:0] clkRatio,
  input logic               clkLockAck,
  input logic               stall,
  input logic [RATIO_W-1:0] curRatio,
  input logic [VCODE_W-1:0] curVcode,
  input logic               busy
);

  assert_req_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(vrReq && clkReq));

  assert_vr_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    vrReq && !vrAck |=> vrReq && $stable(vrCode));

  assert_clk_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    clkReq && !clkLockAck |=> clkReq && $stable(clkRatio));

  assert_volt_commit_R7: assert property (@(posedge clk) disable iff (!rstN)
    vrReq && vrAck |=> curVcode == $past(vrCode));

  assert_up_volt_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    clkReq && (clkRatio > curRatio) |-> curVcode == vrCode);

  assert_down_freq_first_R4: assert property (@(posedge clk) disable iff (!rstN)
    vrReq |-> clkRatio >= curRatio);

  assert_stall_freq_only_R6: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> clkReq && !vrReq);

  assert_stall_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    clkReq && !clkLockAck |-> stall);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !vrReq && !clkReq && !stall);

endmodule

bind vfseq_top vfseq_checker #(.RATIO_W(RATIO_W), .VCODE_W(VCODE_W)) uChecker (
  .clk(clk), .rstN(rstN), .vrReq(vrReq), .vrCode(vrCode), .vrAck(vrAck),
  .clkReq(clkReq), .clkRatio(clkRatio), .clkLockAck(clkLockAck), .stall(stall),
  .curRatio(curRatio), .curVcode(curVcode), .busy(busy)
);

// File: tb/tb_vfseq_top.sv
module tb_vfseq_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tgtValid = 1'b0;
  logic [7:0] tgtRatio = '0;
  logic [7:0] tgtVcode = '0;
  logic       vrReq, clkReq, stall, busy;
  logic [7:0] vrCode, clkRatio, curRatio, curVcode;
  logic       vrAck = 1'b0;
  logic       clkLockAck = 1'b0;

  always #2.5 clk = ~clk;

  vfseq_top dut (
    .clk(clk), .rstN(rstN), .tgtValid(tgtValid), .tgtRatio(tgtRatio),
    .tgtVcode(tgtVcode), .vrReq(vrReq), .vrCode(vrCode), .vrAck(vrAck),
    .clkReq(clkReq), .clkRatio(clkRatio), .clkLockAck(clkLockAck),
    .stall(stall), .curRatio(curRatio), .curVcode(curVcode), .busy(busy)
  );

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  int vrDly   = 0;
  int clkDly  = 0;

  // monitor state
  int   vrCnt, clkCnt, busyCnt, firstStep;
  logic prevVr, prevClk, stallBad, codeBad, overlapBad;
  logic [7:0] expVr, expClk;

  // {ratio, vcode, vrDelay, clkDelay}
  localparam logic [23:0] VEC [8] = '{
    {8'd20, 8'd48, 4'd2, 4'd3},
    {8'd12, 8'd36, 4'd0, 4'd5},
    {8'd12, 8'd44, 4'd3, 4'd1},
    {8'd18, 8'd44, 4'd1, 4'd0},
    {8'd14, 8'd50, 4'd4, 4'd2},
    {8'd22, 8'd30, 4'd6, 4'd4},
    {8'd22, 8'd30, 4'd1, 4'd1},
    {8'd9,  8'd20, 4'd2, 4'd6}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // responders: acknowledge after a programmed number of request cycles
  int vrWait = 0, clkWait = 0;
  always @(negedge clk) begin
    if (vrReq && !vrAck) begin
      if (vrWait >= vrDly) begin vrAck <= 1'b1; vrWait = 0; end
      else vrWait++;
    end else vrAck <= 1'b0;
    if (clkReq && !clkLockAck) begin
      if (clkWait >= clkDly) begin clkLockAck <= 1'b1; clkWait = 0; end
      else clkWait++;
    end else clkLockAck <= 1'b0;
  end

  // monitor samples in the low phase after the responders settle
  always @(negedge clk) begin
    #1;
    cycles++;
    if (busy) busyCnt++;
    if (vrReq && !prevVr) begin vrCnt++; if (firstStep == 0) firstStep = 1; end
    if (clkReq && !prevClk) begin clkCnt++; if (firstStep == 0) firstStep = 2; end
    if (stall != (clkReq && !clkLockAck)) stallBad = 1'b1;
    if (stall && vrReq) stallBad = 1'b1;
    if (vrReq && vrCode != expVr) codeBad = 1'b1;
    if (clkReq && clkRatio != expClk) codeBad = 1'b1;
    if (vrReq && clkReq) overlapBad = 1'b1;
    prevVr  = vrReq;
    prevClk = clkReq;
  end

  task automatic clearMon();
    vrCnt = 0; clkCnt = 0; busyCnt = 0; firstStep = 0;
    stallBad = 0; codeBad = 0; overlapBad = 0;
  endtask

  task automatic strobe(input logic [7:0] r, input logic [7:0] v);
    @(negedge clk);
    tgtValid = 1'b1; tgtRatio = r; tgtVcode = v;
    @(negedge clk);
    tgtValid = 1'b0;
  endtask

  task automatic waitIdle();
    int guard = 0;
    #2;
    while (busy && guard < 500) begin @(negedge clk); #2; guard++; end
    check(guard < 500, "R10 busy falls", guard, 0);
  endtask

  logic [7:0] mRatio = 8'd16, mVcode = 8'd40;

  initial begin
    clearMon();
    prevVr = 0; prevClk = 0; expVr = 0; expClk = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check(curRatio == 8'd16, "R1 curRatio", curRatio, 16);
    check(curVcode == 8'd40, "R1 curVcode", curVcode, 40);
    check({busy, vrReq, clkReq, stall} == 4'b0, "R1 idle outputs",
          {busy, vrReq, clkReq, stall}, 0);

    // R2 timing: busy after first edge, request after second
    expVr = 8'd48; expClk = 8'd20; vrDly = 3; clkDly = 1;
    clearMon();
    @(negedge clk);
    tgtValid = 1'b1; tgtRatio = 8'd20; tgtVcode = 8'd48;
    @(negedge clk); #1;
    tgtValid = 1'b0;
    check(busy && !vrReq && !clkReq, "R2 busy one edge after strobe", busy, 1);
    @(negedge clk); #1;
    check(vrReq == 1'b1, "R2 request two edges after strobe", vrReq, 1);
    waitIdle();
    check(curRatio == 8'd20 && curVcode == 8'd48, "R2 point reached", curRatio, 20);
    // return to reset point
    expVr = 8'd40; expClk = 8'd16;
    strobe(8'd16, 8'd40);
    waitIdle();

    // table walk
    foreach (VEC[i]) begin
      logic [7:0] r, v;
      bit up, rd, vd;
      int expFirst;
      r = VEC[i][23:16]; v = VEC[i][15:8];
      vrDly = int'(VEC[i][7:4]); clkDly = int'(VEC[i][3:0]);
      up = r > mRatio; rd = r != mRatio; vd = v != mVcode;
      if (up) expFirst = vd ? 1 : (rd ? 2 : 0);
      else    expFirst = rd ? 2 : (vd ? 1 : 0);
      expVr = v; expClk = r;
      clearMon();
      strobe(r, v);
      waitIdle();
      check(curRatio == r, "R2 final ratio", curRatio, r);
      check(curVcode == v, "R2 final vcode", curVcode, v);
      check(vrCnt == int'(vd) && clkCnt == int'(rd), "R5 request counts",
            vrCnt * 10 + clkCnt, int'(vd) * 10 + int'(rd));
      if (up) check(firstStep == expFirst, "R3 voltage before clock", firstStep, expFirst);
      else    check(firstStep == expFirst, "R4 clock before voltage", firstStep, expFirst);
      check(!stallBad, "R6 stall window", stallBad, 0);
      check(!codeBad && !overlapBad, "R7 request codes held", codeBad, 0);
      mRatio = r; mVcode = v;
    end

    // R8 equal target: no requests, busy exactly two cycles
    clearMon();
    strobe(mRatio, mVcode);
    waitIdle();
    check(vrCnt == 0 && clkCnt == 0, "R8 no requests", vrCnt + clkCnt, 0);
    check(busyCnt == 2, "R8 busy duration", busyCnt, 2);

    // R9 latest target wins while busy
    vrDly = 4; clkDly = 4;
    clearMon();
    expVr = 8'd30; expClk = 8'd20;
    strobe(8'd20, 8'd30);
    repeat (2) @(negedge clk);
    tgtValid = 1'b1; tgtRatio = 8'd5; tgtVcode = 8'd5;
    @(negedge clk);
    tgtRatio = 8'd15; tgtVcode = 8'd25;
    @(negedge clk);
    tgtValid = 1'b0;
    // wait for first sequence to reach its point before expecting second codes
    while (!(curRatio == 8'd20 && curVcode == 8'd30)) @(negedge clk);
    expVr = 8'd25; expClk = 8'd15;
    waitIdle();
    check(curRatio == 8'd15 && curVcode == 8'd25, "R9 latest target applied",
          curRatio, 15);
    check(vrCnt == 2 && clkCnt == 2, "R9 overwritten target skipped",
          vrCnt * 10 + clkCnt, 22);
    check(!codeBad && !stallBad, "R9 codes and stall", codeBad, 0);

    // R10 quiet when idle
    repeat (3) @(negedge clk);
    #1;
    check(!busy && !vrReq && !clkReq, "R10 idle quiet", busy, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule